// File: doc/BRIEF.md
# Segment LCD serial frame receiver

This block takes display and control data from a host over a three-wire synchronous serial link: a chip-enable line, a serial clock and a data line. While chip enable is low, the host clocks in an 8-bit device address. It then raises chip enable and clocks in one fixed-length frame of 64 bits. The last two bits of the frame say which of four frames it is. Three frames carry 52 display bits each and one carries 48, so together they fill a 204-bit segment register. The first frame also carries a small control word that sets backup (power-saving) mode, forces all segments off, sets a current-drain bit, and says how many of the first twelve segment outputs work as general-purpose ports.

All three serial lines are sampled by the block's own system clock through two-stage synchronizers. The block acts on the falling edge of chip enable. It commits a frame only when the address matched and exactly 64 data bits arrived; any other transfer is dropped without effect. A separate blank request input forces the display state off and returns every port to segment use. Transfers are still received and stored while it is asserted.

Top module: `seg_frame_rx`

## Requirements
- R1: After synchronous reset, the segment register is all zero, backup and all-off read 1, the current-drain bit reads 0, the port mask is 0, blank reads 1 and the commit strobe is 0.
- R2: Address bits are sent least significant bit first, one per rising serial clock while chip enable is low; the last 8 such bits form the address, which must equal the DEV_ADDR parameter (default 0xA6). Data bits are taken on rising serial clocks while chip enable is high, and frame bit i is the i-th data bit. The direction value is frame bit 62 plus twice frame bit 63. Value 0 loads frame bits 0..51 into segment bits 0..51 and latches control from frame bits 52 (backup), 53 (all-off), 54 (current drain) and 55..58 (port count, bit 55 least significant). Frame bits 59..61 are ignored.
- R3: Direction 1 loads frame bits 0..51 into segment bits 52..103, and direction 2 loads them into segment bits 104..155. Frame bits 52..61 are ignored and the control state is unchanged.
- R4: Direction 3 loads frame bits 0..47 into segment bits 156..203. Frame bits 48..61 are ignored and the control state is unchanged.
- R5: A committed frame changes no segment bits outside its own slice.
- R6: A transfer whose address does not equal DEV_ADDR changes no output and raises no commit strobe.
- R7: A transfer with any data bit count other than 64 (for example 0, 63 or 65) changes no output and raises no commit strobe.
- R8: For an accepted frame, the commit strobe is high for exactly one clock cycle, starting after the third rising system-clock edge that follows the fall of chip enable. The new segment and control values appear in that same cycle.
- R9: Port mask bit j is 1 exactly when j is below the stored port count, so any count of 12 or more gives all twelve bits set.
- R10: While blank request is high, the port mask is 0 and blank is 1, and frames are still accepted and stored. When blank request is released, the stored control state shows again.
- R11: Blank equals blank request OR stored all-off OR stored backup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Serial chip enable: low for the address phase, high for the data phase |
| sck_i | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi_i | input | 1 | Serial data |
| blank_req_i | input | 1 | Forces the display state off and all ports back to segment use |
| seg_o | output | 204 | Segment register |
| backup_o | output | 1 | Stored backup (power-saving) mode flag |
| all_off_o | output | 1 | Stored force-all-segments-off flag |
| cu_o | output | 1 | Stored current-drain select bit |
| port_mask_o | output | 12 | 1 where a leading segment output acts as a general-purpose port |
| blank_o | output | 1 | Effective display-off state |
| commit_o | output | 1 | One-cycle strobe for an accepted frame |

## Verification
A serial input change reaches the logic after two synchronizer flops and is acted on at the third rising system-clock edge. The commit strobe, the segment register and the control fields are therefore due in the cycle after that edge. The bench drives every serial edge on a falling system-clock edge. After each fall of chip enable it samples the strobe on the falling edge after the second rising edge (expected low), after the third (expected high for accepted frames) and after the fourth (expected low again), and only then compares the full segment register and control outputs. Blank and port mask are combinational in blank request, so they are sampled on the next falling edge after it changes.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

    localparam int SEG_W    = 204;
    localparam int WIDE_W   = 52;
    localparam int NARROW_W = 48;
    localparam int FRAMES   = 4;
    localparam int DIR_W    = $clog2(FRAMES);
    localparam int PCNT_W   = 4;
    localparam int PORTS    = 12;
    localparam int CTL_LO   = WIDE_W;
    localparam int CTL_W    = 3 + PCNT_W;

    typedef enum logic [DIR_W-1:0] {
        FRM_LOW   = 2'd0,
        FRM_MID_A = 2'd1,
        FRM_MID_B = 2'd2,
        FRM_HIGH  = 2'd3
    } frame_e;

    typedef struct packed {
        logic              backup;
        logic              all_off;
        logic              cu;
        logic [PCNT_W-1:0] port_cnt;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{backup: 1'b1, all_off: 1'b1, cu: 1'b0, port_cnt: '0};

    function automatic ctrl_t ctrl_unpack(input logic [CTL_W-1:0] w);
        ctrl_t c;
        c.backup   = w[0];
        c.all_off  = w[1];
        c.cu       = w[2];
        c.port_cnt = w[CTL_W-1:3];
        return c;
    endfunction

    function automatic logic [PORTS-1:0] ports_from_count(input logic [PCNT_W-1:0] n);
        logic [PORTS-1:0] m;
        for (int j = 0; j < PORTS; j++) begin
            m[j] = (j < int'(n));
        end
        return m;
    endfunction

    function automatic int slice_width(input int g);
        return (g == FRAMES - 1) ? NARROW_W : WIDE_W;
    endfunction

endpackage

// File: rtl/seg_rx_sync.sv
module seg_rx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage <= '0;
            end else begin
                stage <= {stage[0], d_in[i]};
            end
        end
        assign q_out[i] = stage[1];
    end

endmodule

// File: rtl/seg_rx_shift.sv
module seg_rx_shift
    import seg_rx_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA6,
    parameter int               FRAME_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              sck,
    input  logic              sdi,
    output logic              frame_done,
    output logic [WIDE_W-1:0] disp,
    output logic [CTL_W-1:0]  ctl,
    output logic [DIR_W-1:0]  dir
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    logic               ce_d;
    logic               sck_d;
    logic               addr_ok;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  areg;
    logic [FRAME_W-1:0] sreg;
    logic               sck_rise;
    logic               ce_rise;
    logic               ce_fall;

    assign sck_rise = sck & ~sck_d;
    assign ce_rise  = ce & ~ce_d;
    assign ce_fall  = ~ce & ce_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_d    <= 1'b0;
            sck_d   <= 1'b0;
            addr_ok <= 1'b0;
            cnt     <= '0;
            areg    <= '0;
            sreg    <= '0;
        end else begin
            ce_d  <= ce;
            sck_d <= sck;
            if (ce_rise) begin
                cnt     <= '0;
                addr_ok <= (areg == DEV_ADDR);
            end else if (ce_fall) begin
                addr_ok <= 1'b0;
            end else if (sck_rise) begin
                if (ce) begin
                    sreg <= {sdi, sreg[FRAME_W-1:1]};
                    if (cnt != CNT_SAT) begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    areg <= {sdi, areg[ADDR_W-1:1]};
                end
            end
        end
    end

    assign frame_done = ce_fall & addr_ok & (cnt == CNT_FULL);
    assign disp       = sreg[WIDE_W-1:0];
    assign ctl        = sreg[CTL_LO +: CTL_W];
    assign dir        = sreg[FRAME_W-1 -: DIR_W];

    // R8: an accepted frame never yields two back-to-back done pulses
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done)
        else $error("frame_done held for two cycles");

    // R7: the bit counter never wraps back from saturation while data is still clocked
    assert_cnt_nowrap_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_SAT) && ce && ce_d |=> (cnt == CNT_SAT))
        else $error("bit counter wrapped");

endmodule

// File: rtl/seg_rx_store.sv
module seg_rx_store
    import seg_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [WIDE_W-1:0] disp,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [DIR_W-1:0]  dir,
    output logic [SEG_W-1:0]  seg_q,
    output ctrl_t             ctrl_q,
    output logic              commit_q
);

    frame_e sel;
    assign sel = frame_e'(dir);

    for (genvar g = 0; g < FRAMES; g++) begin : g_slice
        localparam int SW   = slice_width(g);
        localparam int BASE = g * WIDE_W;
        logic [SW-1:0] slice_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slice_q <= '0;
            end else if (frame_done && (sel == frame_e'(g))) begin
                slice_q <= disp[SW-1:0];
            end
        end
        assign seg_q[BASE +: SW] = slice_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            commit_q <= 1'b0;
        end else begin
            commit_q <= frame_done;
            if (frame_done && (sel == FRM_LOW)) begin
                ctrl_q <= ctrl_unpack(ctl);
            end
        end
    end

    // R8: commit strobe lasts one cycle
    assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q)
        else $error("commit strobe longer than one cycle");

    // R5: the segment register moves only in a commit cycle
    assert_seg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_q) |-> commit_q)
        else $error("segment register changed without commit");

    // R3: control fields move only in a commit cycle
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> commit_q)
        else $error("control changed without commit");

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
    import seg_rx_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA6,
    parameter int               FRAME_W  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             sck_i,
    input  logic             sdi_i,
    input  logic             blank_req_i,
    output logic [SEG_W-1:0] seg_o,
    output logic             backup_o,
    output logic             all_off_o,
    output logic             cu_o,
    output logic [PORTS-1:0] port_mask_o,
    output logic             blank_o,
    output logic             commit_o
);

    logic [2:0]        sync_q;
    logic              frame_done;
    logic [WIDE_W-1:0] disp;
    logic [CTL_W-1:0]  ctl;
    logic [DIR_W-1:0]  dir;
    ctrl_t             ctrl_q;

    seg_rx_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({sdi_i, sck_i, ce_i}),
        .q_out (sync_q)
    );

    seg_rx_shift #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR),
        .FRAME_W  (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ce         (sync_q[0]),
        .sck        (sync_q[1]),
        .sdi        (sync_q[2]),
        .frame_done (frame_done),
        .disp       (disp),
        .ctl        (ctl),
        .dir        (dir)
    );

    seg_rx_store u_store (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .disp       (disp),
        .ctl        (ctl),
        .dir        (dir),
        .seg_q      (seg_o),
        .ctrl_q     (ctrl_q),
        .commit_q   (commit_o)
    );

    assign backup_o    = ctrl_q.backup;
    assign all_off_o   = ctrl_q.all_off;
    assign cu_o        = ctrl_q.cu;
    assign port_mask_o = blank_req_i ? '0 : ports_from_count(ctrl_q.port_cnt);
    assign blank_o     = blank_req_i | ctrl_q.all_off | ctrl_q.backup;

    // R9: the port mask is always a contiguous run from bit 0, at most PORTS wide
    assert_port_prefix_R9: assert property (@(posedge clk) disable iff (rst)
        ((port_mask_o & (port_mask_o + PORTS'(1))) == '0) &&
        ($countones(port_mask_o) <= PORTS))
        else $error("port mask not a prefix");

    // R10: while blank is requested, nothing shows through as a port one cycle later
    assert_blank_ports_R10: assert property (@(posedge clk) disable iff (rst)
        blank_req_i && $past(blank_req_i) |-> (port_mask_o == '0) && blank_o)
        else $error("port or display active under blank request");

endmodule

// File: tb/seg_frame_rx_bench.sv
module seg_frame_rx_bench;

    localparam logic [7:0] ADDR = 8'hA6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ce_i = 1'b0;
    logic         sck_i = 1'b0;
    logic         sdi_i = 1'b0;
    logic         blank_req_i = 1'b0;
    logic [203:0] seg_o;
    logic         backup_o, all_off_o, cu_o, blank_o, commit_o;
    logic [11:0]  port_mask_o;

    int checks = 0;
    int fails  = 0;

    logic [203:0] exp_seg;
    logic         exp_bk, exp_ao, exp_cu;
    logic [3:0]   exp_pc;

    always #5 clk = ~clk;

    seg_frame_rx u_seg_frame_rx (
        .clk         (clk),
        .rst         (rst),
        .ce_i        (ce_i),
        .sck_i       (sck_i),
        .sdi_i       (sdi_i),
        .blank_req_i (blank_req_i),
        .seg_o       (seg_o),
        .backup_o    (backup_o),
        .all_off_o   (all_off_o),
        .cu_o        (cu_o),
        .port_mask_o (port_mask_o),
        .blank_o     (blank_o),
        .commit_o    (commit_o)
    );

    task automatic chk(input string tag, input logic [203:0] act, input logic [203:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [11:0] exp_mask();
        logic [11:0] m = '0;
        for (int j = 0; j < 12; j++) if (j < int'(exp_pc)) m[j] = 1'b1;
        if (blank_req_i) m = '0;
        return m;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " seg"}, seg_o, exp_seg);
        chk({tag, " backup"}, 204'(backup_o), 204'(exp_bk));
        chk({tag, " all_off"}, 204'(all_off_o), 204'(exp_ao));
        chk({tag, " cu"}, 204'(cu_o), 204'(exp_cu));
        chk({tag, " port_mask"}, 204'(port_mask_o), 204'(exp_mask()));
        chk({tag, " blank"}, 204'(blank_o), 204'(blank_req_i | exp_ao | exp_bk));
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdi_i = b;
        half();
        sck_i = 1'b1;
        half();
        sck_i = 1'b0;
    endtask

    function automatic logic [63:0] mk(input logic [1:0] d, input logic [51:0] disp,
                                       input logic [9:0] ctl);
        return {d, ctl, disp};
    endfunction

    task automatic model(input logic [63:0] f);
        case (f[63:62])
            2'd0: begin
                exp_seg[51:0] = f[51:0];
                exp_bk = f[52];
                exp_ao = f[53];
                exp_cu = f[54];
                exp_pc = f[58:55];
            end
            2'd1: exp_seg[103:52]  = f[51:0];
            2'd2: exp_seg[155:104] = f[51:0];
            default: exp_seg[203:156] = f[47:0];
        endcase
    endtask

    task automatic send(input logic [7:0] a, input logic [63:0] f, input int n,
                        input bit want, input string tag);
        for (int i = 0; i < 8; i++) pulse(a[i]);
        half();
        ce_i = 1'b1;
        half();
        for (int i = 0; i < n; i++) pulse((i < 64) ? f[i] : 1'b1);
        half();
        ce_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({"R8 early ", tag}, 204'(commit_o), 204'(0));
        @(posedge clk);
        @(negedge clk);
        chk({"R8 strobe ", tag}, 204'(commit_o), 204'(want));
        if (want) model(f);
        if (want) check_state({"R8 data ", tag});
        @(posedge clk);
        @(negedge clk);
        chk({"R8 strobe end ", tag}, 204'(commit_o), 204'(0));
        check_state(tag);
    endtask

    function automatic logic [51:0] rnd52();
        logic [63:0] r = {$urandom(), $urandom()};
        return r[51:0];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [9:0] c;
        exp_seg = '0;
        exp_bk = 1'b1; exp_ao = 1'b1; exp_cu = 1'b0; exp_pc = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset");
        chk("R1 reset commit", 204'(commit_o), 204'(0));

        // R2 R9 R11: sweep every port count with varied flags
        for (int k = 0; k < 16; k++) begin
            c = {3'($urandom()), 4'(k), 1'(k[0] ^ k[1]), 1'(k[1]), 1'(k[2] & k[3])};
            send(ADDR, mk(2'd0, rnd52(), c), 64, 1'b1, "R2 R9 R11 ctrl");
        end
        send(ADDR, mk(2'd0, rnd52(), {3'b101, 4'd7, 3'b100}), 64, 1'b1, "R2 R11 visible");

        // R3 R4 R5: other slices with random fixed bits
        for (int p = 0; p < 3; p++) begin
            for (int d = 1; d < 4; d++) begin
                send(ADDR, mk(2'(d), rnd52(), 10'($urandom())), 64, 1'b1, "R3 R4 R5 slice");
            end
        end

        // R6: wrong address
        send(ADDR ^ 8'h01, mk(2'd1, rnd52(), 10'h3FF), 64, 1'b0, "R6 addr lsb");
        send(ADDR ^ 8'h80, mk(2'd0, rnd52(), 10'h000), 64, 1'b0, "R6 addr msb");

        // R7: wrong counts
        send(ADDR, mk(2'd2, rnd52(), 10'h155), 63, 1'b0, "R7 short");
        send(ADDR, mk(2'd3, rnd52(), 10'h2AA), 65, 1'b0, "R7 long");
        send(ADDR, mk(2'd0, rnd52(), 10'h000), 0, 1'b0, "R7 empty");

        // R10: blank request
        blank_req_i = 1'b1;
        @(negedge clk);
        check_state("R10 blank on");
        send(ADDR, mk(2'd2, rnd52(), 10'h0F0), 64, 1'b1, "R10 data under blank");
        send(ADDR, mk(2'd0, rnd52(), {3'b000, 4'd5, 3'b000}), 64, 1'b1, "R10 ctrl under blank");
        blank_req_i = 1'b0;
        @(negedge clk);
        check_state("R10 blank released");
        chk("R10 R9 mask five", 204'(port_mask_o), 204'(12'h01F));
        send(ADDR, mk(2'd0, rnd52(), {3'b000, 4'd12, 3'b010}), 64, 1'b1, "R9 R11 twelve");
        chk("R9 mask full", 204'(port_mask_o), 204'(12'hFFF));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule